// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides one unsigned integer by another over several clock cycles. Its width `WIDTH` is a parameter with a default of 32 bits. A one-cycle `start` strobe is accepted only while the block is idle. On that edge the block captures the dividend and the divisor. It then produces one quotient bit per cycle. Each cycle does a single addition or subtraction of the divisor against a partial remainder that carries one extra sign bit. The operation is picked from the sign left by the previous step, so the block never restores the remainder after each step. After `WIDTH` such cycles, one correction cycle adds the divisor back if the remainder ended up negative. The block then raises `done` for a single cycle.

The quotient and the remainder stay on the outputs until the next accepted start. A zero divisor is not treated as an error in the datapath. The block raises the `div_by_zero` flag, and `done` still arrives on its usual cycle. The quotient and remainder from such a division carry no meaning. Signed division and quotient overflow are the caller's concern.

Top module: `nonrestore_divider`

## Requirements
- R1: While `rst_n` is low and after it is released, `done`, `busy`, `div_by_zero`, `quotient` and `remainder` are all 0 until a start is accepted.
- R2: A high `start` in the idle state is accepted at that clock edge. `busy` is 1 from the next cycle through the cycle in which `done` is high, and it is 0 in the cycle after that.
- R3: `done` is high for exactly one cycle. That cycle is the one that follows the WIDTH+1-th rising edge after the accepting edge. `done` is 0 in every earlier cycle of the division.
- R4: For a nonzero divisor, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor while `done` is high. This holds for extreme operands such as all-ones values and a divisor larger than the dividend.
- R5: For a nonzero divisor, `remainder` is smaller than the captured divisor while `done` is high. Also, quotient×divisor+remainder equals the dividend.
- R6: A `start` pulse given while `busy` is high is ignored. The division in progress keeps its operands, its result and its `done` cycle.
- R7: A zero divisor sets `div_by_zero` to 1 at the accepting edge. `done` still comes on the R3 cycle. The flag is held until the next start is accepted, and a nonzero divisor then clears it.
- R8: After `done`, `quotient`, `remainder` and `div_by_zero` hold their values, and `done` stays 0, until the next start is accepted. Changes on `dividend` and `divisor` have no effect in that time.
- R9: With `WIDTH` set to 4, every dividend in 0..15 with every divisor in 1..15 gives the correct quotient and remainder after 5 cycles. One example is 8/3, which gives quotient 2 and remainder 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division, accepted only when idle |
| dividend | input | WIDTH | Unsigned dividend, sampled at the accepting edge |
| divisor | input | WIDTH | Unsigned divisor, sampled at the accepting edge |
| busy | output | 1 | A division is in progress or finishing |
| done | output | 1 | One-cycle pulse, results valid |
| div_by_zero | output | 1 | The captured divisor was zero |
| quotient | output | WIDTH | Quotient of the last division |
| remainder | output | WIDTH | Remainder of the last division |

## Verification
Results are due WIDTH+1 cycles after the edge that accepts `start`. That is 33 cycles at the default width and 5 cycles at width 4. `busy` rises one cycle after that edge, and `done` falls one cycle after it rose. The bench drives `start` on a falling edge and counts falling edges from the accepting edge on. It requires `done` to be 0 at each of the first WIDTH samples, 1 at the next one, and 0 again at the one after. It reads the quotient, remainder and flag only in the `done` sample, and it reads held values several cycles later.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2,
        ST_DONE = 2'd3
    } nrdiv_state_e;
endpackage

// File: rtl/nrdiv_addsub.sv
// One (W)-bit adder shared by the iteration and the correction step.
module nrdiv_addsub #(
    parameter int W = 33
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = b ^ {W{sub}};
        y     = a + b_eff + {{(W-1){1'b0}}, sub};
    end
endmodule

// File: rtl/nrdiv_ctrl.sv
// Sequencer: idle -> WIDTH iteration cycles -> one correction -> done pulse.
module nrdiv_ctrl
    import nrdiv_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    output nrdiv_state_e state_o
);
    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        nrdiv_state_e st;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st  = ST_ITER;
                    c_d.cnt = CW'(N);
                end
            end
            ST_ITER: begin
                c_d.cnt = c_q.cnt - CW'(1);
                if (c_q.cnt == CW'(1)) c_d.st = ST_FIX;
            end
            ST_FIX:  c_d.st = ST_DONE;
            ST_DONE: c_d.st = ST_IDLE;
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st  <= ST_IDLE;
            c_q.cnt <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign state_o = c_q.st;

    // R2: an idle start is taken at once
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_IDLE && start) |=> (c_q.st == ST_ITER && c_q.cnt == CW'(N)));
    // R3: last iteration hands over to the correction cycle
    a_r3_fix_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_ITER && c_q.cnt == CW'(1)) |=> (c_q.st == ST_FIX));
    // R3: done lasts one cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_DONE) |=> (c_q.st == ST_IDLE));
    // R6: start cannot disturb a running count
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_ITER && c_q.cnt > CW'(1)) |=> (c_q.st == ST_ITER && c_q.cnt == $past(c_q.cnt) - CW'(1)));
endmodule

// File: rtl/nonrestore_divider.sv
module nonrestore_divider
    import nrdiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic             div_by_zero,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);
    localparam int RW = WIDTH + 1;

    typedef struct packed {
        logic [RW-1:0]    r;
        logic [WIDTH-1:0] q;
        logic [RW-1:0]    m;
        logic             dz;
    } dp_t;

    dp_t d_d, d_q;
    nrdiv_state_e state;

    logic [RW-1:0]    r_shift;
    logic [WIDTH-1:0] q_shift;
    logic [RW-1:0]    add_a;
    logic             add_sub;
    logic [RW-1:0]    add_y;

    nrdiv_ctrl #(.N(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .state_o (state)
    );

    // Remainder and quotient shifted left together as one register pair.
    always_comb begin
        r_shift = {d_q.r[WIDTH-1:0], d_q.q[WIDTH-1]};
        q_shift = {d_q.q[WIDTH-2:0], 1'b0};
        add_a   = (state == ST_FIX) ? d_q.r : r_shift;
        add_sub = (state == ST_ITER) && !d_q.r[RW-1];
    end

    nrdiv_addsub #(.W(RW)) u_addsub (
        .a   (add_a),
        .b   (d_q.m),
        .sub (add_sub),
        .y   (add_y)
    );

    always_comb begin
        d_d = d_q;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    d_d.r  = '0;
                    d_d.q  = dividend;
                    d_d.m  = {1'b0, divisor};
                    d_d.dz = (divisor == '0);
                end
            end
            ST_ITER: begin
                d_d.r = add_y;
                d_d.q = {q_shift[WIDTH-1:1], ~add_y[RW-1]};
            end
            ST_FIX: begin
                if (d_q.r[RW-1]) d_d.r = add_y;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign busy        = (state != ST_IDLE);
    assign done        = (state == ST_DONE);
    assign div_by_zero = d_q.dz;
    assign quotient    = d_q.q;
    assign remainder   = d_q.r[WIDTH-1:0];

    // R4: the correction leaves a non-negative remainder
    a_r4_fix_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIX && !d_q.dz) |=> !d_q.r[RW-1]);
    // R5: remainder below divisor when results are presented
    a_r5_rem_below: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero) |-> (remainder < d_q.m[WIDTH-1:0]));
    // R7: the flag moves only at an accepting edge
    a_r7_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(d_q.dz));
    // R8: results are held while idle without a start
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> ($stable(quotient) && $stable(remainder)));
    // R6: divisor register is frozen while busy
    a_r6_divisor_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(d_q.m));
endmodule

// File: tb/sim_nonrestore_divider.sv
module sim_nonrestore_divider;
    localparam int W  = 32;
    localparam int WS = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          st, bsy, dn, dz;
    logic [W-1:0]  dvd, dvs, quo, rem;
    logic          st4, bsy4, dn4, dz4;
    logic [WS-1:0] dvd4, dvs4, quo4, rem4;

    int checks = 0;
    int fails  = 0;

    nonrestore_divider #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(st), .dividend(dvd), .divisor(dvs),
        .busy(bsy), .done(dn), .div_by_zero(dz), .quotient(quo), .remainder(rem)
    );

    nonrestore_divider #(.WIDTH(WS)) u1 (
        .clk(clk), .rst_n(rst_n), .start(st4), .dividend(dvd4), .divisor(dvs4),
        .busy(bsy4), .done(dn4), .div_by_zero(dz4), .quotient(quo4), .remainder(rem4)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] q;
        logic [31:0] r;
    } vec_t;

    localparam vec_t VECS [0:11] = '{
        '{32'd100,        32'd7,          32'd14,         32'd2},
        '{32'd8,          32'd3,          32'd2,          32'd2},
        '{32'd0,          32'd5,          32'd0,          32'd0},
        '{32'd5,          32'd9,          32'd0,          32'd5},
        '{32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF,   32'd0},
        '{32'hFFFFFFFF,   32'hFFFFFFFF,   32'd1,          32'd0},
        '{32'hFFFFFFFF,   32'd2,          32'h7FFFFFFF,   32'd1},
        '{32'd1000000,    32'd3,          32'd333333,     32'd1},
        '{32'h80000000,   32'h80000001,   32'd0,          32'h80000000},
        '{32'h12345678,   32'h10,         32'h01234567,   32'h8},
        '{32'hFFFFFFFF,   32'h10000,      32'hFFFF,       32'hFFFF},
        '{32'd1,          32'hFFFFFFFF,   32'd0,          32'd1}
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Start at a falling edge; sample only at falling edges afterwards.
    task automatic run32(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke,
                         output logic [W-1:0] q, output logic [W-1:0] r,
                         output bit z, output bit on_time, output bit busy_ok);
        bit early = 0;
        @(negedge clk);
        dvd = a; dvs = b; st = 1'b1;
        @(negedge clk);            // accepting edge has passed
        st = 1'b0;
        busy_ok = bsy;
        for (int i = 1; i <= W; i++) begin
            @(negedge clk);
            if (dn) early = 1;
            if (!bsy) busy_ok = 0;
            if (poke && i == 3) begin
                st = 1'b1; dvd = 32'd50; dvs = 32'd5;
            end else begin
                st = 1'b0;
            end
        end
        @(negedge clk);
        on_time = dn && !early;
        if (!bsy) busy_ok = 0;
        q = quo; r = rem; z = dz;
        @(negedge clk);
        if (dn) on_time = 0;
        if (bsy) busy_ok = 0;
    endtask

    task automatic run4(input logic [WS-1:0] a, input logic [WS-1:0] b,
                        output logic [WS-1:0] q, output logic [WS-1:0] r, output bit on_time);
        bit early = 0;
        @(negedge clk);
        dvd4 = a; dvs4 = b; st4 = 1'b1;
        @(negedge clk);
        st4 = 1'b0;
        for (int i = 1; i <= WS; i++) begin
            @(negedge clk);
            if (dn4) early = 1;
        end
        @(negedge clk);
        on_time = dn4 && !early;
        q = quo4; r = rem4;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] q, r, hq, hr;
        logic [WS-1:0] q4, r4;
        bit z, ot, bok;

        rst_n = 1'b0; st = 0; dvd = '0; dvs = '0; st4 = 0; dvd4 = '0; dvs4 = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset outputs", {dn, bsy, dz, quo, rem}, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "after release", {dn, bsy, dz, quo, rem}, '0);

        // R4 R3 R2: table of vectors
        foreach (VECS[k]) begin
            run32(VECS[k].a, VECS[k].b, 1'b0, q, r, z, ot, bok);
            chk("R4", "quotient", q, VECS[k].q);
            chk("R4", "remainder", r, VECS[k].r);
            chk("R3", "done timing", ot, 1);
            chk("R2", "busy window", bok, 1);
        end

        // R5: random operands with several magnitudes
        for (int n = 0; n < 40; n++) begin
            logic [W-1:0] a, b;
            a = $urandom() >> ($urandom() % 32);
            b = ($urandom() >> ($urandom() % 32)) | 32'd1;
            run32(a, b, 1'b0, q, r, z, ot, bok);
            chk("R4", "random quotient", q, a / b);
            chk("R5", "q*d+r", 64'(q) * 64'(b) + 64'(r), 64'(a));
            chk("R5", "rem below divisor", (r < b), 1);
        end

        // R6: start during busy ignored
        run32(32'd100, 32'd7, 1'b1, q, r, z, ot, bok);
        chk("R6", "quotient kept", q, 32'd14);
        chk("R6", "remainder kept", r, 32'd2);
        chk("R6", "done timing kept", ot, 1);

        // R8: hold after done, inputs changing
        hq = quo; hr = rem;
        dvd = 32'hDEADBEEF; dvs = 32'd0;
        repeat (4) @(negedge clk);
        chk("R8", "held quotient", quo, hq);
        chk("R8", "held remainder", rem, hr);
        chk("R8", "done stays low", {dn, dz}, 2'b00);

        // R7: zero divisor flagged, done on time, cleared by next start
        run32(32'd77, 32'd0, 1'b0, q, r, z, ot, bok);
        chk("R7", "flag set", z, 1);
        chk("R7", "done on time", ot, 1);
        repeat (3) @(negedge clk);
        chk("R7", "flag held", dz, 1);
        run32(32'd9, 32'd4, 1'b0, q, r, z, ot, bok);
        chk("R7", "flag cleared", z, 0);
        chk("R7", "next quotient", {q, r}, {32'd2, 32'd1});

        // R9: exhaustive width-4 sweep
        for (int a = 0; a < 16; a++) begin
            for (int b = 1; b < 16; b++) begin
                run4(WS'(a), WS'(b), q4, r4, ot);
                chk("R9", "w4 result", {ot, q4, r4}, {1'b1, 4'(a / b), 4'(a % b)});
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule